// File: doc/BRIEF.md
# Dual-Priority Descriptor Mailbox

This block hands packet descriptors from a switching core to a host processor. The core pushes each descriptor into one of two circular rings, one for urgent traffic and one for ordinary traffic. Each ring keeps a producer index and a read pointer. Each ring also feeds its own holding register, and the processor reads that register.

A descriptor moves from a ring into its holding register only when the ring is non-empty and the holding register is free. Each such move raises the register's valid flag and advances that ring's read pointer. When the processor reads a holding register, the valid flag clears. This frees the register for the next entry, so no separate pop command exists. The interrupt output is a level. It is asserted while any unmasked holding register has its valid flag set.

A descriptor has the following layout, from most to least significant bit:
- entry kind: 0 means packet, 1 means new-address notice
- seven flags, in order: multicast, unicast, broadcast, intervention, unknown destination, new address, extra status
- 4-bit source port
- 16-bit byte count
- 32-bit buffer address

Top module: `desc_mbox`

## Requirements
- R1: After synchronous reset, both valid flags are 0, the interrupt is 0 and both rings report not full.
- R2: A descriptor pushed into an empty ring whose holding register is free appears there, bit for bit, with its valid flag set, one clock after the edge that sampled the push.
- R3: Within one ring, descriptors reach the holding register in the order they were pushed, including when the pointers wrap past the ring depth.
- R4: A read strobe sampled while the holding register is valid clears its valid flag on that edge. If the ring still holds entries, the next one loads on the following edge.
- R5: While a holding register is valid and not read, its contents stay unchanged and pending ring entries are held back.
- R6: When both holding registers could load on the same edge, only the urgent one loads. The ordinary one loads on the next edge.
- R7: The interrupt equals (urgent valid AND NOT irq_mask[0]) OR (ordinary valid AND NOT irq_mask[1]).
- R8: A ring reports full exactly when DEPTH pushed entries are still waiting to be loaded. Full clears once one of them moves to the holding register.
- R9: A read strobe sampled while the holding register is not valid has no effect: the valid flag stays 0, the contents are unchanged and later loads proceed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Producer enqueues one descriptor this cycle |
| push_prio | input | 1 | Target ring: 0 urgent, 1 ordinary |
| push_desc | input | 60 | Descriptor being enqueued |
| rd_hi | input | 1 | Processor read strobe for the urgent holding register |
| rd_lo | input | 1 | Processor read strobe for the ordinary holding register |
| irq_mask | input | 2 | Bit 0 masks urgent, bit 1 masks ordinary |
| hi_valid | output | 1 | Urgent holding register holds an unread descriptor |
| hi_desc | output | 60 | Urgent holding register contents |
| lo_valid | output | 1 | Ordinary holding register holds an unread descriptor |
| lo_desc | output | 60 | Ordinary holding register contents |
| hi_full | output | 1 | Urgent ring has DEPTH waiting entries |
| lo_full | output | 1 | Ordinary ring has DEPTH waiting entries |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the producer never pushes into a ring whose full output is high. They also assume that a ring is popped only while it holds entries, so the pointer checks judge only legal traffic. The stimulus watches the full flags and stops pushing at exactly DEPTH waiting entries. Read strobes are issued both with and without a valid descriptor present, since the design must tolerate a stray read.

// File: rtl/desc_mbox_pkg.sv
package desc_mbox_pkg;

    localparam int PORT_W = 4;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 32;
    localparam int NQ     = 2;   // index 0 urgent, index 1 ordinary

    typedef enum logic {
        ENT_PACKET  = 1'b0,
        ENT_NEWADDR = 1'b1
    } ent_kind_e;

    typedef struct packed {
        logic mcast;
        logic ucast;
        logic bcast;
        logic interv;
        logic unknown;
        logic new_addr;
        logic extra;
    } desc_flags_t;

    typedef struct packed {
        ent_kind_e           kind;
        desc_flags_t         flags;
        logic [PORT_W-1:0]   src_port;
        logic [CNT_W-1:0]    byte_cnt;
        logic [ADDR_W-1:0]   buf_addr;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    // Lowest index wins: one load per cycle, urgent first.
    function automatic logic [NQ-1:0] pick_load(input logic [NQ-1:0] can);
        logic [NQ-1:0] r;
        r = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (can[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/desc_ring.sv
module desc_ring
    import desc_mbox_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  desc_t push_desc,
    input  logic  pop,
    output desc_t head,
    output logic  not_empty,
    output logic  full
);
    localparam int PW = $clog2(DEPTH);

    desc_t       slots [DEPTH];
    logic [PW:0] prod_idx;
    logic [PW:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_idx <= '0;
            rd_ptr   <= '0;
        end else begin
            if (push) prod_idx <= prod_idx + 1'b1;
            if (pop)  rd_ptr   <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[prod_idx[PW-1:0]] <= push_desc;
    end

    assign head      = slots[rd_ptr[PW-1:0]];
    assign not_empty = (prod_idx != rd_ptr);
    assign full      = (prod_idx[PW] != rd_ptr[PW]) &&
                       (prod_idx[PW-1:0] == rd_ptr[PW-1:0]);

    // R8: producer respects the full flag
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R3: a ring is only drained while it holds entries
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> not_empty);

endmodule

// File: rtl/desc_hold.sv
module desc_hold
    import desc_mbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  desc_t load_desc,
    input  logic  rd,
    output logic  valid,
    output desc_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_desc;
        end else if (rd) begin
            valid <= 1'b0;
        end
    end

    // R5: a load never overwrites an unread descriptor
    a_r5_load_when_free: assert property (@(posedge clk) disable iff (rst)
        load |-> !valid);

    // R4: a read of a valid register drains it
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (valid && rd) |=> !valid);

    // R5: unread contents are held
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd) |=> (valid && $stable(data)));

    // R9: a stray read changes nothing
    a_r9_stray_read: assert property (@(posedge clk) disable iff (rst)
        (!valid && rd && !load) |=> (!valid && $stable(data)));

endmodule

// File: rtl/desc_mbox.sv
module desc_mbox
    import desc_mbox_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic              push_prio,
    input  logic [DESC_W-1:0] push_desc,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic [NQ-1:0]     irq_mask,
    output logic              hi_valid,
    output logic [DESC_W-1:0] hi_desc,
    output logic              lo_valid,
    output logic [DESC_W-1:0] lo_desc,
    output logic              hi_full,
    output logic              lo_full,
    output logic              irq
);
    desc_t          head_q [NQ];
    desc_t          data_q [NQ];
    logic [NQ-1:0]  ne_q;
    logic [NQ-1:0]  full_q;
    logic [NQ-1:0]  valid_q;
    logic [NQ-1:0]  can_q;
    logic [NQ-1:0]  load_q;
    logic [NQ-1:0]  rd_q;
    logic [NQ-1:0]  push_q;

    assign rd_q = {rd_lo, rd_hi};

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign push_q[g] = push_valid && (int'(push_prio) == g);

        desc_ring #(.DEPTH(DEPTH)) u_ring (
            .clk       (clk),
            .rst       (rst),
            .push      (push_q[g]),
            .push_desc (desc_t'(push_desc)),
            .pop       (load_q[g]),
            .head      (head_q[g]),
            .not_empty (ne_q[g]),
            .full      (full_q[g])
        );

        desc_hold u_hold (
            .clk       (clk),
            .rst       (rst),
            .load      (load_q[g]),
            .load_desc (head_q[g]),
            .rd        (rd_q[g]),
            .valid     (valid_q[g]),
            .data      (data_q[g])
        );

        assign can_q[g] = ne_q[g] && !valid_q[g];

        // R2: a granted load shows up as a valid holding register
        a_r2_load_sets_valid: assert property (@(posedge clk) disable iff (rst)
            load_q[g] |=> valid_q[g]);
    end

    assign load_q = pick_load(can_q);

    assign hi_valid = valid_q[0];
    assign lo_valid = valid_q[1];
    assign hi_desc  = data_q[0];
    assign lo_desc  = data_q[1];
    assign hi_full  = full_q[0];
    assign lo_full  = full_q[1];
    assign irq      = |(valid_q & ~irq_mask);

    // R6: at most one ring is moved per cycle
    a_r6_one_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_q));

    // R6: the ordinary ring waits while the urgent one is loading
    a_r6_lo_waits: assert property (@(posedge clk) disable iff (rst)
        (load_q[1] && can_q[0]) |-> 1'b0);

    // R7: an unmasked valid register always interrupts
    a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
        ((hi_valid && !irq_mask[0]) || (lo_valid && !irq_mask[1])) |-> irq);

endmodule

// File: tb/desc_mbox_tb.sv
`timescale 1ns/1ps
module desc_mbox_tb;
    import desc_mbox_pkg::*;

    localparam int DEPTH = 4;
    localparam int NV    = 6;

    // {prio, descriptor}
    localparam logic [DESC_W:0] VEC [NV] = '{
        {1'b0, 1'b0, 7'b1000000, 4'h1, 16'd64,   32'h1000_0000},
        {1'b1, 1'b1, 7'b0000010, 4'h2, 16'd0,    32'h0000_0000},
        {1'b0, 1'b0, 7'b0010000, 4'hF, 16'hFFFF, 32'hFFFF_FFFF},
        {1'b1, 1'b0, 7'b0101001, 4'h7, 16'd1518, 32'h2345_6780},
        {1'b0, 1'b1, 7'b1111111, 4'h0, 16'd1,    32'hDEAD_BEE0},
        {1'b1, 1'b0, 7'b0100100, 4'hA, 16'd256,  32'h0BAD_F000}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              push_valid;
    logic              push_prio;
    logic [DESC_W-1:0] push_desc;
    logic              rd_hi;
    logic              rd_lo;
    logic [NQ-1:0]     irq_mask;
    logic              hi_valid;
    logic [DESC_W-1:0] hi_desc;
    logic              lo_valid;
    logic [DESC_W-1:0] lo_desc;
    logic              hi_full;
    logic              lo_full;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    desc_mbox #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_prio(push_prio),
        .push_desc(push_desc), .rd_hi(rd_hi), .rd_lo(rd_lo), .irq_mask(irq_mask),
        .hi_valid(hi_valid), .hi_desc(hi_desc), .lo_valid(lo_valid), .lo_desc(lo_desc),
        .hi_full(hi_full), .lo_full(lo_full), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic p, input logic [DESC_W-1:0] d);
        push_valid = 1'b1;
        push_prio  = p;
        push_desc  = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic rd(input logic p);
        if (p) rd_lo = 1'b1;
        else   rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        rd_lo = 1'b0;
    endtask

    function automatic logic [DESC_W-1:0] mk(input int k);
        return {1'b0, 7'b0100000, 4'(k), 16'(100 + k), 32'hA000_0000 + 32'(k)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DESC_W-1:0] x, y, a, b, z;
        rst = 1'b1; push_valid = 1'b0; push_prio = 1'b0; push_desc = '0;
        rd_hi = 1'b0; rd_lo = 1'b0; irq_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 hi_valid", hi_valid, 0);
        check("R1 lo_valid", lo_valid, 0);
        check("R1 irq", irq, 0);
        check("R1 full", {hi_full, lo_full}, 0);

        // Table walk: R2 load, R7 interrupt, R4 read clears
        for (int i = 0; i < NV; i++) begin
            push(VEC[i][DESC_W], VEC[i][DESC_W-1:0]);
            @(negedge clk);
            if (VEC[i][DESC_W]) begin
                check("R2 lo_valid", lo_valid, 1);
                check("R2 lo_desc", lo_desc, VEC[i][DESC_W-1:0]);
                check("R2 hi idle", hi_valid, 0);
            end else begin
                check("R2 hi_valid", hi_valid, 1);
                check("R2 hi_desc", hi_desc, VEC[i][DESC_W-1:0]);
                check("R2 lo idle", lo_valid, 0);
            end
            check("R7 irq unmasked", irq, 1);
            rd(VEC[i][DESC_W]);
            check("R4 cleared", {hi_valid, lo_valid}, 0);
            check("R7 irq low", irq, 0);
        end

        // R3/R4/R5: ordering and hold-back in the urgent ring
        push(1'b0, mk(1));
        push(1'b0, mk(2));
        push(1'b0, mk(3));
        repeat (3) @(negedge clk);
        check("R5 first held", hi_desc, mk(1));
        check("R5 still valid", hi_valid, 1);
        rd(1'b0);
        check("R4 read clears", hi_valid, 0);
        @(negedge clk);
        check("R4 reload", hi_valid, 1);
        check("R3 second", hi_desc, mk(2));
        rd(1'b0);
        @(negedge clk);
        check("R3 third", hi_desc, mk(3));
        rd(1'b0);
        @(negedge clk);
        check("R4 empty stays clear", hi_valid, 0);

        // R6 priority
        x = mk(4); y = mk(5); a = mk(6); b = mk(7);
        push(1'b0, x);
        push(1'b1, y);
        @(negedge clk);
        push(1'b0, a);
        push(1'b1, b);
        @(negedge clk);
        check("R5 hi unchanged", hi_desc, x);
        check("R5 lo unchanged", lo_desc, y);
        rd_hi = 1'b1; rd_lo = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0; rd_lo = 1'b0;
        check("R4 both cleared", {hi_valid, lo_valid}, 0);
        @(negedge clk);
        check("R6 hi first", {hi_valid, lo_valid}, 2'b10);
        check("R6 hi data", hi_desc, a);
        @(negedge clk);
        check("R6 lo next", lo_valid, 1);
        check("R6 lo data", lo_desc, b);

        // R7 masking
        irq_mask = 2'b01; #1; check("R7 lo unmasked", irq, 1);
        irq_mask = 2'b11; #1; check("R7 all masked", irq, 0);
        rd(1'b1);
        irq_mask = 2'b10; #1; check("R7 hi unmasked", irq, 1);
        irq_mask = 2'b01; #1; check("R7 hi masked", irq, 0);
        irq_mask = 2'b00;

        // R8 full and wrap (urgent holding register still holds a)
        for (int k = 0; k < DEPTH; k++) push(1'b0, mk(10 + k));
        check("R8 hi full", hi_full, 1);
        check("R8 lo not full", lo_full, 0);
        check("R5 a held", hi_desc, a);
        for (int k = 0; k < DEPTH; k++) begin
            rd(1'b0);
            @(negedge clk);
            check("R3 wrap order", hi_desc, mk(10 + k));
            if (k == 0) check("R8 full cleared", hi_full, 0);
        end
        rd(1'b0);

        // R9 stray read on the ordinary side (holds b, not valid)
        rd(1'b1);
        check("R9 lo still clear", lo_valid, 0);
        check("R9 lo contents", lo_desc, b);
        z = mk(20);
        push(1'b1, z);
        @(negedge clk);
        check("R9 later load", lo_desc, z);
        check("R9 later valid", lo_valid, 1);

        // R1 reset mid-traffic
        push(1'b0, mk(21));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears", {hi_valid, lo_valid, irq, hi_full, lo_full}, 0);
        @(negedge clk);
        check("R1 rings empty", {hi_valid, lo_valid}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule